// File: doc/BRIEF.md
# Radio Power State Controller

This block tracks the low-power states of a radio core from the slave side of its serial port. Decoded command strobes arrive with a one-cycle valid pulse, next to the active-low chip select. The block drives three outputs: the crystal oscillator enable, the enable for the digital-core regulator, and an active-low chip-ready flag that a host sees while it selects the part. Crystal start-up is modelled by a counter of `START_CYCLES` clock edges. The chip-ready flag falls only when that count is complete.

From IDLE, the host issues either a crystal-off strobe or a power-down strobe while it holds chip select low. The block does not act on the strobe until the host releases chip select. It then enters XOFF, where the crystal is off, or SLEEP, where the crystal and the regulator are both off. When chip select is pulled low again, the block moves to a wake state and waits for the crystal to stabilise before it returns to IDLE. A force-on configuration bit keeps the crystal running in every state; in that case a wake-up needs no stabilisation wait. A software-reset strobe restores the default state from any state.

Top module: `radio_pwr_ctrl`

## Requirements
- R1: After the synchronous reset, the state is IDLE, the crystal and regulator enables are 1, chip-ready-low is 1, and the ignored-command flag is 0.
- R2: Strobe codes on `cmd_code` are 2'b00 software reset, 2'b01 crystal-off and 2'b10 power-down. A crystal-off or power-down strobe taken in IDLE is held pending, and the state stays IDLE for as long as `cs_n` is 0. At the first rising edge where `cs_n` is 1, the state moves to XOFF (crystal-off) or SLEEP (power-down). State codes on `state` are IDLE 2'b00, XOFF 2'b01, SLEEP 2'b10 and WAKE 2'b11.
- R3: When force-on is clear, the crystal enable is 0 in XOFF and SLEEP. The regulator enable is 0 only in SLEEP.
- R4: If `cs_n` is 0 at a rising edge in XOFF or SLEEP, the next state is WAKE, with the crystal and regulator enabled. WAKE moves to IDLE at the first rising edge where chip-ready-low is already 0.
- R5: While `force_xosc_on` is 1, the crystal enable is 1 in every state. A wake-up from XOFF or SLEEP whose crystal count is already complete goes straight to IDLE at the next edge.
- R6: Chip-ready-low is 0 exactly when the crystal enable was 1 at each of the last `START_CYCLES` rising edges since the most recent reset or software reset.
- R7: A crystal-off or power-down strobe received outside IDLE changes no state and sets the ignored-command flag. The flag stays set until a reset or a software reset.
- R8: A software-reset strobe in any state gives IDLE at the next edge. It drops any pending strobe, clears the ignored-command flag, and restarts the crystal count, so chip-ready-low is 1 again for `START_CYCLES` edges.
- R9: Strobe code 2'b11 has no effect on the state, the pending strobe or the ignored-command flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| cmd_valid | input | 1 | One-cycle strobe valid |
| cmd_code | input | 2 | Decoded strobe code |
| force_xosc_on | input | 1 | Keeps the crystal on in all states |
| xosc_en | output | 1 | Crystal oscillator enable |
| vreg_en | output | 1 | Digital regulator enable |
| chip_rdy_n | output | 1 | Low once the crystal is stable |
| state | output | 2 | Current power state |
| cmd_ignored | output | 1 | Sticky flag: a strobe was refused |

## Verification
The assertions assume two things about the inputs. First, reset is held low for at least two edges. Second, `cmd_valid` and `cmd_code` are treated as valid only in the cycle they are sampled; no handshake or stability over time is assumed. The stimulus changes every input on the falling clock edge and holds reset for several cycles. It drives strobes in every state, including the illegal ones, toggles force-on while the crystal is off, and applies software resets during both wake-up and SLEEP. This covers every path the assertions guard.

// File: rtl/pwr_ctrl_pkg.sv
// Package: shared state and strobe encodings for the radio power controller.
// Assumes: state and strobe codes are visible at the block's ports.
package pwr_ctrl_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'b00,
        PS_XOFF  = 2'b01,
        PS_SLEEP = 2'b10,
        PS_WAKE  = 2'b11
    } pwr_state_e;

    typedef enum logic [1:0] {
        STB_RESET      = 2'b00,
        STB_XTAL_OFF   = 2'b01,
        STB_POWER_DOWN = 2'b10,
        STB_NOP        = 2'b11
    } strobe_e;

endpackage

// File: rtl/strobe_decode.sv
// Module: turns a strobe code plus its valid pulse into a software-reset
// request and a power request with its target low-power state.
// Assumes: cmd_code is meaningful only in the cycle where cmd_valid is 1.
module strobe_decode
    import pwr_ctrl_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    output logic       sres,
    output logic       req_valid,
    output pwr_state_e req_target
);

    // Decode the strobe; the no-op code produces no request.
    always_comb begin
        sres       = 1'b0;
        req_valid  = 1'b0;
        req_target = PS_IDLE;
        if (cmd_valid) begin
            unique case (strobe_e'(cmd_code))
                STB_RESET:      sres = 1'b1;
                STB_XTAL_OFF:   begin req_valid = 1'b1; req_target = PS_XOFF;  end
                STB_POWER_DOWN: begin req_valid = 1'b1; req_target = PS_SLEEP; end
                default:        ;
            endcase
        end
    end

endmodule

// File: rtl/xosc_timer.sv
// Module: models crystal start-up by counting the edges at which the crystal
// enable is 1, and flags the crystal as stable at START_CYCLES.
// Assumes: restart is a one-cycle request; the count saturates and does not wrap.
module xosc_timer #(
    parameter int unsigned START_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic xosc_en,
    output logic stable
);

    localparam int unsigned CNT_W = $clog2(START_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(START_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Clear the count while the crystal is off; otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (!xosc_en) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign stable = (cnt_q == CNT_MAX);

    // R6: a crystal that is off cannot be stable one edge later.
    p_off_not_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!xosc_en && !restart) |=> !stable);

    // R6: the counter never passes its limit.
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

endmodule

// File: rtl/pwr_fsm.sv
// Module: the power state machine. It holds a pending low-power request
// until chip select is released, wakes when chip select is pulled low, and
// keeps a sticky flag for strobes it refused.
// Assumes: stable comes from the crystal timer; sres takes priority over all else.
module pwr_fsm
    import pwr_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sres,
    input  logic       req_valid,
    input  pwr_state_e req_target,
    input  logic       stable,
    output pwr_state_e st_q,
    output logic       ign_q
);

    pwr_state_e st_n;
    pwr_state_e pend_q, pend_n;
    logic       ign_n;

    // Next-state, pending-request and refused-strobe logic.
    always_comb begin
        st_n   = st_q;
        pend_n = pend_q;
        ign_n  = ign_q;
        if (sres) begin
            st_n   = PS_IDLE;
            pend_n = PS_IDLE;
            ign_n  = 1'b0;
        end else begin
            unique case (st_q)
                PS_IDLE: begin
                    if (req_valid) pend_n = req_target;
                    if (cs_n && (pend_n != PS_IDLE)) begin
                        st_n   = pend_n;
                        pend_n = PS_IDLE;
                    end
                end
                PS_XOFF, PS_SLEEP: begin
                    if (req_valid) ign_n = 1'b1;
                    if (!cs_n) st_n = stable ? PS_IDLE : PS_WAKE;
                end
                default: begin
                    if (req_valid) ign_n = 1'b1;
                    if (stable) st_n = PS_IDLE;
                end
            endcase
        end
    end

    // State, pending-request and flag registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PS_IDLE;
            pend_q <= PS_IDLE;
            ign_q  <= 1'b0;
        end else begin
            st_q   <= st_n;
            pend_q <= pend_n;
            ign_q  <= ign_n;
        end
    end

    // R2: the state stays IDLE while the chip is still selected.
    p_hold_while_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_IDLE && !cs_n && !sres) |=> st_q == PS_IDLE);

    // R2: low-power states are entered only from IDLE, never from WAKE.
    p_no_sleep_from_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_WAKE) |=> (st_q != PS_XOFF && st_q != PS_SLEEP));

    // R4: selecting the chip in a low-power state always starts a wake-up.
    p_wake_on_select_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == PS_XOFF || st_q == PS_SLEEP) && !cs_n && !sres)
        |=> (st_q == PS_WAKE || st_q == PS_IDLE));

    // R7: the refused-strobe flag is sticky.
    p_sticky_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ign_q && !sres) |=> ign_q);

    // R8: software reset lands in IDLE with the flag cleared.
    p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sres |=> (st_q == PS_IDLE && !ign_q));

endmodule

// File: rtl/radio_pwr_ctrl.sv
// Module: top of the radio power state controller. It connects the strobe
// decoder, the state machine and the crystal timer, and derives the crystal
// and regulator enables from the state and the force-on bit.
// Assumes: synchronous active-low reset held for at least two edges.
module radio_pwr_ctrl
    import pwr_ctrl_pkg::*;
#(
    parameter int unsigned START_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_code,
    input  logic       force_xosc_on,
    output logic       xosc_en,
    output logic       vreg_en,
    output logic       chip_rdy_n,
    output logic [1:0] state,
    output logic       cmd_ignored
);

    logic       sres;
    logic       req_valid;
    pwr_state_e req_target;
    pwr_state_e st;
    logic       stable;

    strobe_decode u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .sres       (sres),
        .req_valid  (req_valid),
        .req_target (req_target)
    );

    pwr_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sres       (sres),
        .req_valid  (req_valid),
        .req_target (req_target),
        .stable     (stable),
        .st_q       (st),
        .ign_q      (cmd_ignored)
    );

    xosc_timer #(.START_CYCLES(START_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (sres),
        .xosc_en (xosc_en),
        .stable  (stable)
    );

    // Crystal runs in IDLE and WAKE, or anywhere when forced on.
    always_comb xosc_en = force_xosc_on || st == PS_IDLE || st == PS_WAKE;

    // Regulator is off only in SLEEP.
    always_comb vreg_en = (st != PS_SLEEP);

    assign chip_rdy_n = ~stable;
    assign state      = st;

    // R5: the force-on bit keeps the crystal running whatever the state.
    p_force_keeps_xtal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_xosc_on |-> xosc_en);

    // R3: leaving SLEEP always brings the regulator back.
    p_reg_back_after_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_SLEEP && !cs_n && !sres) |=> vreg_en);

endmodule

// File: tb/sim_radio_pwr_ctrl.sv
// Bench: a behavioural reference model runs next to the design and is
// compared on every clock, with directed checks at the corner cases.
module sim_radio_pwr_ctrl;

    localparam int START = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic cs_n = 1;
    logic cmd_valid = 0;
    logic [1:0] cmd_code = 0;
    logic force_xosc_on = 0;
    logic xosc_en, vreg_en, chip_rdy_n, cmd_ignored;
    logic [1:0] state;

    int vectors = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;   // 50 MHz

    radio_pwr_ctrl #(.START_CYCLES(START)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .force_xosc_on(force_xosc_on),
        .xosc_en(xosc_en), .vreg_en(vreg_en), .chip_rdy_n(chip_rdy_n),
        .state(state), .cmd_ignored(cmd_ignored)
    );

    // Reference model: 0 IDLE, 1 XOFF, 2 SLEEP, 3 WAKE; pend 0 none.
    int m_st = 0, m_cnt = 0, m_pend = 0, m_ign = 0;

    function automatic int m_xosc();
        return (force_xosc_on || m_st == 0 || m_st == 3) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int old_cnt, x, np;
        old_cnt = m_cnt;
        x = m_xosc();
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pend = 0; m_ign = 0;
        end else if (cmd_valid && cmd_code == 2'b00) begin
            m_st = 0; m_cnt = 0; m_pend = 0; m_ign = 0;       // R8
        end else begin
            if (x == 0) m_cnt = 0;
            else if (m_cnt < START) m_cnt = m_cnt + 1;
            if (m_st == 0) begin
                np = m_pend;
                if (cmd_valid && (cmd_code == 2'b01 || cmd_code == 2'b10)) np = cmd_code;
                if (cs_n && np != 0) begin m_st = np; m_pend = 0; end
                else m_pend = np;
            end else begin
                if (cmd_valid && (cmd_code == 2'b01 || cmd_code == 2'b10)) m_ign = 1;
                if (m_st == 3) begin
                    if (old_cnt == START) m_st = 0;
                end else if (!cs_n) begin
                    m_st = (old_cnt == START) ? 0 : 3;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    task automatic compare_all();
        check("R2", "state", state, m_st);
        check("R3", "xosc_en", xosc_en, m_xosc());
        check("R3", "vreg_en", vreg_en, (m_st != 2) ? 1 : 0);
        check("R6", "chip_rdy_n", chip_rdy_n, (m_cnt == START) ? 0 : 1);
        check("R7", "cmd_ignored", cmd_ignored, m_ign);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic strobe(input logic [1:0] c);
        cmd_valid = 1; cmd_code = c;
        tick();
        cmd_valid = 0; cmd_code = 2'b11;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values, just after release.
        check("R1", "state", state, 0);
        check("R1", "xosc_en", xosc_en, 1);
        check("R1", "vreg_en", vreg_en, 1);
        check("R1", "chip_rdy_n", chip_rdy_n, 1);
        check("R1", "cmd_ignored", cmd_ignored, 0);
        // R6: ready falls after START edges of running crystal.
        repeat (START - 1) tick();
        check("R6", "not yet ready", chip_rdy_n, 1);
        tick();
        check("R6", "ready", chip_rdy_n, 0);

        // R2: crystal-off held while selected, taken on release.
        cs_n = 0; tick();
        strobe(2'b01);
        repeat (3) tick();
        check("R2", "held in IDLE", state, 0);
        cs_n = 1; tick();
        check("R2", "XOFF entered", state, 1);
        check("R3", "crystal off in XOFF", xosc_en, 0);
        tick();
        // R7: power-down in XOFF is refused and flagged.
        strobe(2'b10);
        check("R7", "state kept", state, 1);
        check("R7", "flag set", cmd_ignored, 1);
        // R9: no-op code leaves everything.
        strobe(2'b11);
        check("R9", "no-op state", state, 1);
        // R4: wake via chip select.
        cs_n = 0; tick();
        check("R4", "WAKE", state, 3);
        check("R4", "crystal on in WAKE", xosc_en, 1);
        repeat (START) tick();
        check("R4", "ready at end of wait", chip_rdy_n, 0);
        check("R4", "still WAKE", state, 3);
        tick();
        check("R4", "back to IDLE", state, 0);
        check("R7", "flag sticky", cmd_ignored, 1);

        // R8: software reset clears the flag and restarts the count.
        strobe(2'b00);
        check("R8", "flag cleared", cmd_ignored, 0);
        check("R8", "not ready", chip_rdy_n, 1);
        repeat (START + 2) tick();

        // R3: power-down then SLEEP, regulator off.
        strobe(2'b10);
        cs_n = 1; tick();
        check("R3", "SLEEP", state, 2);
        check("R3", "regulator off", vreg_en, 0);
        tick();
        // R8: software reset from SLEEP.
        strobe(2'b00);
        check("R8", "IDLE from SLEEP", state, 0);
        repeat (START + 2) tick();

        // R5: forced crystal, sleep and wake without a wait.
        force_xosc_on = 1; cs_n = 0; tick();
        strobe(2'b10);
        cs_n = 1; tick();
        check("R5", "SLEEP with crystal", xosc_en, 1);
        repeat (3) tick();
        check("R5", "ready kept", chip_rdy_n, 0);
        cs_n = 0; tick();
        check("R5", "direct IDLE", state, 0);
        // R9: no-op in IDLE keeps it there when released.
        strobe(2'b11);
        cs_n = 1; tick();
        check("R9", "no-op in IDLE", state, 0);
        force_xosc_on = 0;

        // Mixed stimulus against the model.
        for (int i = 0; i < 600; i++) begin
            if ($urandom % 5 == 0) cs_n = ~cs_n;
            if ($urandom % 40 == 0) force_xosc_on = ~force_xosc_on;
            cmd_valid = ($urandom % 7 == 0);
            cmd_code = 2'($urandom);
            if (cmd_code == 2'b00 && ($urandom % 3 != 0)) cmd_code = 2'b01;
            tick();
            cmd_valid = 0;
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule